// File: doc/BRIEF.md
# RMS-Tracking Digital Automatic Gain Control

This block sits at the tail of a receive filter chain and keeps the power of the complex samples it passes on close to a level chosen by software. Each accepted I/Q sample adds its instantaneous power I²+Q² to a block average taken over a programmable number of samples. When a block of samples is complete, the mean power is converted to a coarse base-2 logarithm. The loop then adds the current gain in the same log scale and compares the result with a programmed reference. The difference, divided by a programmable power of two that sets the loop time constant, moves a log-domain gain register. That register is saturated to a 96 dB span.

The same gain scales every sample on the way through. Its integer part selects a shift and its four fractional bits select an entry of a sixteen-entry 2^x mantissa. The scaled sample is then cut to one of four output resolutions, with round-half-up and symmetric saturation. A hold input freezes the gain, for example during a burst gap or a calibration interval.

Top module: `rms_agc`

## Requirements
- R1: After reset `gain_log` is 128 (unity gain), `out_valid` is 0 and `out_i`/`out_q` are 0.
- R2: Only samples with `in_valid` high count. A block holds 2^N of them, N = `cfg_win` (0..7), and its mean power is floor(sum(I²+Q²) / 2^N).
- R3: The log of the mean power is 16·p + b, where p is the index of its highest set bit and b is the four bits just below that bit (zero-filled). A mean of zero gives 0.
- R4: One clock after the sample that completes a block, the gain becomes clamp(g − (e >>> (`cfg_shift`+1)), 0, 256). Here e = log(mean) + 2·(g − 128) − `cfg_ref`, with arithmetic (floor) shift. The gain changes at no other time.
- R5: When `hold` is high in the clock where an update would happen, the gain keeps its value.
- R6: `gain_log` g encodes the amplitude gain 2^(g/16 − 8): 0 is −48 dB, 256 is +48 dB. The mantissa for fraction f = g mod 16 is round(16384·2^(f/16)).
- R7: `out_valid` follows `in_valid` by one clock. The output of a sample uses the gain that was held before the edge that accepted it.
- R8: `cfg_width` selects the output width W: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4. The output is x·gain / 2^(16−W), rounded half up (toward +∞ on exact halves), and sign-extended to 16 bits.
- R9: The output saturates symmetrically to ±(2^(W−1) − 1). A result of −2^(W−1) is also clipped to −(2^(W−1) − 1).
- R10: Cycles with `in_valid` low leave the block count, the average and `out_i`/`out_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| cfg_win | input | 3 | Block length exponent N (2^N samples) |
| cfg_ref | input | 9 | Reference power, log2 with 4 fractional bits |
| cfg_shift | input | 3 | Loop time-constant shift (error divided by 2^(shift+1)) |
| cfg_width | input | 2 | Output width select (16/12/8/4) |
| hold | input | 1 | Freeze the gain |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Scaled in-phase sample, sign-extended |
| out_q | output | 16 | Scaled quadrature sample, sign-extended |
| gain_log | output | 9 | Current gain, log2 with 4 fractional bits, offset 128 |

## Verification
The corners that are hardest to reach from the ports are the two rails of the gain and the clipping at the extreme rail. To reach them, the stimulus pairs a tiny input with a very high reference, which drives the gain to 256, and then applies full-scale and most-negative samples at every output width. A full-scale input with a zero reference then drives the gain to 0. The hold input freezes it there, so that exact half-LSB rounding cases can be aimed at. Valid gaps, block-length changes and hold pulses over the update cycle are mixed in, and a behavioural model follows the whole sequence clock by clock.

// File: rtl/rms_agc.sv
module rms_agc #(
  parameter int DW = 16,
  parameter int NW = 3,
  parameter int SW = 3,
  localparam int LW = $clog2(2*DW) + 4,
  localparam int GW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [NW-1:0]        cfg_win,
  input  logic [LW-1:0]        cfg_ref,
  input  logic [SW-1:0]        cfg_shift,
  input  logic [1:0]           cfg_width,
  input  logic                 hold,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [GW-1:0]        gain_log
);
  localparam int PW   = 2*DW;
  localparam int CW   = (1 << NW) - 1;
  localparam int ACW  = PW + CW;
  localparam int PB   = $clog2(PW);
  localparam int EW   = LW + 3;
  localparam int GMID = 128;
  localparam int GMAX = 256;
  localparam int MB   = 14;
  localparam int PRW  = DW + 20;

  function automatic logic [15:0] mant_of(input logic [3:0] f);
    case (f)
      4'd0:  return 16'd16384;
      4'd1:  return 16'd17109;
      4'd2:  return 16'd17867;
      4'd3:  return 16'd18658;
      4'd4:  return 16'd19484;
      4'd5:  return 16'd20347;
      4'd6:  return 16'd21247;
      4'd7:  return 16'd22188;
      4'd8:  return 16'd23170;
      4'd9:  return 16'd24196;
      4'd10: return 16'd25268;
      4'd11: return 16'd26386;
      4'd12: return 16'd27554;
      4'd13: return 16'd28774;
      4'd14: return 16'd30048;
      default: return 16'd31379;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [15:0] m,
                                                 input logic [5:0] s,
                                                 input logic signed [PRW-1:0] l);
    logic signed [PRW-1:0] p, r;
    p = PRW'(x) * $signed(PRW'(m));
    r = (p + (PRW'(1) <<< (s - 1))) >>> s;
    if (r > l) r = l;
    else if (r < -l) r = -l;
    return DW'(r);
  endfunction

  logic [ACW-1:0] acc, psum;
  logic [CW-1:0]  cnt, win_max;
  logic           upd, win_last;
  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]  pw, mean, norm;
  logic [PB-1:0]  msb;
  logic [LW-1:0]  lg;
  logic signed [EW-1:0] err, step;
  logic signed [EW:0]   gn;
  logic [GW-1:0]  g_next;
  logic [15:0]    mant;
  logic [5:0]     sh;
  logic signed [PRW-1:0] lim;

  assign win_max  = CW'((64'd1 << cfg_win) - 64'd1);
  assign win_last = cnt >= win_max;
  assign sq_i     = PW'(in_i) * PW'(in_i);
  assign sq_q     = PW'(in_q) * PW'(in_q);
  assign pw       = $unsigned(sq_i) + $unsigned(sq_q);
  assign mean     = PW'(psum >> cfg_win);

  always_comb begin
    msb = '0;
    for (int k = 0; k < PW; k++)
      if (mean[k]) msb = PB'(k);
    norm = mean << (PW - 1 - int'(msb));
    lg   = (mean == '0) ? '0 : {msb, norm[PW-2 -: 4]};
  end

  assign err    = $signed(EW'(lg) + (EW'(gain_log) << 1) - EW'(2*GMID) - EW'(cfg_ref));
  assign step   = err >>> ((SW+1)'(cfg_shift) + 1'b1);
  assign gn     = $signed((EW+1)'(gain_log)) - (EW+1)'(step);
  assign g_next = (gn < 0) ? '0 : (gn > GMAX) ? GW'(GMAX) : gn[GW-1:0];

  assign mant = mant_of(gain_log[3:0]);
  assign sh   = 6'(MB + GMID/16 + 4*int'(cfg_width) - int'(gain_log[GW-1:4]));
  assign lim  = (PRW'(1) <<< (DW - 1 - 4*int'(cfg_width))) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      psum      <= '0;
      cnt       <= '0;
      upd       <= 1'b0;
      gain_log  <= GW'(GMID);
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      upd       <= in_valid && win_last;
      out_valid <= in_valid;
      if (in_valid) begin
        if (win_last) begin
          psum <= acc + ACW'(pw);
          acc  <= '0;
          cnt  <= '0;
        end else begin
          acc  <= acc + ACW'(pw);
          cnt  <= cnt + 1'b1;
        end
        out_i <= scale(in_i, mant, sh, lim);
        out_q <= scale(in_q, mant, sh, lim);
      end
      if (upd && !hold) gain_log <= g_next;
    end
  end
endmodule

module rms_agc_chk #(
  parameter int DW = 16,
  parameter int GW = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 hold,
  input logic [1:0]           cfg_width,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [GW-1:0]        gain_log
);
  assert_gain_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_log <= GW'(256));

  // R4 and R5: a change needs a sample two clocks back and no hold one clock back
  assert_gain_when_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_log != $past(gain_log)) |-> ($past(in_valid, 2) && !$past(hold)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_sym_clip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_i) <= (1 << (DW-1-4*int'($past(cfg_width)))) - 1) &&
                  (int'(out_i) >= 1 - (1 << (DW-1-4*int'($past(cfg_width))))) &&
                  (int'(out_q) <= (1 << (DW-1-4*int'($past(cfg_width)))) - 1) &&
                  (int'(out_q) >= 1 - (1 << (DW-1-4*int'($past(cfg_width))))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind rms_agc rms_agc_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hold(hold),
  .cfg_width(cfg_width), .out_valid(out_valid), .out_i(out_i),
  .out_q(out_q), .gain_log(gain_log)
);

// File: tb/sim_rms_agc.sv
module sim_rms_agc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [2:0] cfg_win = 3'd3;
  logic [8:0] cfg_ref = 9'd320;
  logic [2:0] cfg_shift = 3'd2;
  logic [1:0] cfg_width = 2'd0;
  logic hold = 1'b0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;
  logic [8:0] gain_log;

  always #5 clk = ~clk;

  rms_agc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_win(cfg_win), .cfg_ref(cfg_ref), .cfg_shift(cfg_shift),
    .cfg_width(cfg_width), .hold(hold), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .gain_log(gain_log)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [31:0] seed = 32'h1234_5678;

  longint m_acc = 0, m_psum = 0;
  int m_cnt = 0, m_gain = 128, m_oi = 0, m_oq = 0;
  bit m_upd = 0, m_ov = 0;

  task automatic chk(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int rnd(int amp);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return (int'(seed[30:15]) % (2*amp + 1)) - amp;
  endfunction

  function automatic int blog(longint m);
    int p;
    int b;
    if (m == 0) return 0;
    p = 0;
    for (int k = 0; k < 40; k++) if ((m >> k) != 0) p = k;
    if (p >= 4) b = int'((m >> (p - 4)) & 15);
    else b = int'((m << (4 - p)) & 15);
    return 16*p + b;
  endfunction

  function automatic longint bmant(int f);
    return longint'($rtoi(16384.0 * (2.0 ** (f / 16.0)) + 0.5));
  endfunction

  function automatic int bscale(int x, int g, int w);
    longint p, r, lim;
    int s;
    p = longint'(x) * bmant(g % 16);
    s = 22 + 4*w - g/16;
    r = (p + (longint'(1) << (s - 1))) >>> s;
    lim = (longint'(1) << (15 - 4*w)) - 1;
    if (r > lim) r = lim;
    if (r < -lim) r = -lim;
    return int'(r);
  endfunction

  task automatic step(bit v, int i, int q);
    longint pw, n_acc, n_psum, mean;
    int n_cnt, n_gain, n_oi, n_oq, e, st;
    bit n_upd;
    in_valid = v; in_i = 16'(i); in_q = 16'(q);
    pw = longint'(i)*i + longint'(q)*q;
    n_acc = m_acc; n_psum = m_psum; n_cnt = m_cnt; n_upd = 0;
    n_oi = m_oi; n_oq = m_oq; n_gain = m_gain;
    if (v) begin
      if (m_cnt >= (1 << cfg_win) - 1) begin
        n_psum = m_acc + pw; n_acc = 0; n_cnt = 0; n_upd = 1;
      end else begin
        n_acc = m_acc + pw; n_cnt = m_cnt + 1;
      end
      n_oi = bscale(i, m_gain, int'(cfg_width));
      n_oq = bscale(q, m_gain, int'(cfg_width));
    end
    if (m_upd && !hold) begin
      mean = m_psum >> cfg_win;
      e = blog(mean) + 2*(m_gain - 128) - int'(cfg_ref);
      st = e >>> (int'(cfg_shift) + 1);
      n_gain = m_gain - st;
      if (n_gain < 0) n_gain = 0;
      if (n_gain > 256) n_gain = 256;
    end
    @(posedge clk); @(negedge clk);
    m_acc = n_acc; m_psum = n_psum; m_cnt = n_cnt; m_upd = n_upd;
    m_oi = n_oi; m_oq = n_oq; m_gain = n_gain; m_ov = v;
    chk("gain_log", longint'(gain_log), m_gain);
    chk("out_valid", longint'(out_valid), longint'(m_ov));
    chk("out_i", longint'(out_i), m_oi);
    chk("out_q", longint'(out_q), m_oq);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int g0;
    repeat (4) @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    chk("gain_log", longint'(gain_log), 128);
    chk("out_valid", longint'(out_valid), 0);
    chk("out_i", longint'(out_i), 0);
    chk("out_q", longint'(out_q), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R6 R7: steady tracking, block of 8
    cur_req = "R2";
    for (int n = 0; n < 600; n++) step(1, rnd(4000), rnd(4000));
    cur_req = "R3";
    cfg_win = 3'd1; cfg_ref = 9'd200;
    for (int n = 0; n < 300; n++) step(1, rnd(900), rnd(300));
    cur_req = "R6";
    cfg_width = 2'd1; cfg_ref = 9'd360;
    for (int n = 0; n < 300; n++) step(1, rnd(20000), rnd(20000));

    // R10: valid gaps, block of 32
    cur_req = "R10";
    cfg_win = 3'd5; cfg_width = 2'd0; cfg_shift = 3'd1;
    for (int n = 0; n < 800; n++) step(rnd(1) != 0, rnd(6000), rnd(6000));

    // R5: hold freezes gain across several completed blocks
    cur_req = "R5";
    cfg_win = 3'd2; cfg_ref = 9'd100;
    hold = 1'b1;
    g0 = int'(gain_log);
    for (int n = 0; n < 200; n++) step(1, rnd(10000), rnd(10000));
    chk("held gain", longint'(gain_log), g0);
    hold = 1'b0;
    for (int n = 0; n < 100; n++) begin
      hold = (n % 7) == 3;
      step(1, rnd(10000), rnd(10000));
    end
    hold = 1'b0;

    // R4: upper rail
    cur_req = "R4";
    cfg_win = 3'd0; cfg_shift = 3'd0; cfg_ref = 9'd480;
    for (int n = 0; n < 400; n++) step(1, rnd(50), rnd(50));
    chk("gain upper rail", longint'(gain_log), 256);

    // R9: clipping at every width with the gain at +48 dB
    cur_req = "R9";
    hold = 1'b1;
    for (int w = 0; w < 4; w++) begin
      cfg_width = 2'(w);
      step(1, -32768, 32767);
      chk("neg clip", longint'(out_i), -((1 << (15 - 4*w)) - 1));
      chk("pos clip", longint'(out_q), (1 << (15 - 4*w)) - 1);
      for (int n = 0; n < 40; n++) step(1, rnd(32767), rnd(200));
    end
    hold = 1'b0;

    // R4: lower rail
    cur_req = "R4";
    cfg_width = 2'd0; cfg_ref = 9'd0;
    for (int n = 0; n < 400; n++) step(1, 32767, rnd(32767));
    chk("gain lower rail", longint'(gain_log), 0);

    // R8: rounding at gain 0 (x/256 at 16 bits)
    cur_req = "R8";
    hold = 1'b1;
    step(1, 1000, -640);
    chk("round 3.906", longint'(out_i), 4);
    chk("round -2.5 half up", longint'(out_q), -2);
    for (int w = 0; w < 4; w++) begin
      cfg_width = 2'(w);
      for (int n = 0; n < 50; n++) step(1, rnd(32767), rnd(32767));
    end
    hold = 1'b0;

    // R3: zero input gives a zero log, mid reference
    cur_req = "R3";
    cfg_width = 2'd2; cfg_ref = 9'd40; cfg_shift = 3'd3;
    for (int n = 0; n < 200; n++) step(1, 0, 0);
    for (int n = 0; n < 200; n++) step(1, rnd(3), rnd(3));

    // R2: longest block, slow loop
    cur_req = "R2";
    cfg_win = 3'd7; cfg_shift = 3'd4; cfg_ref = 9'd300; cfg_width = 2'd0;
    for (int n = 0; n < 1500; n++) step((n % 5) != 0, rnd(12000), rnd(12000));
    cfg_shift = 3'd7;
    for (int n = 0; n < 600; n++) step(1, rnd(30000), rnd(30000));

    // R7: isolated samples
    cur_req = "R7";
    cfg_win = 3'd0;
    for (int n = 0; n < 60; n++) step((n % 3) == 0, rnd(2000), rnd(2000));
    step(0, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule